// File: doc/BRIEF.md
# Offset Calibration Sequencer

This block decides when an analog front end has to run its offset calibration and supervises each run. It watches two supply comparator flags, a temperature drift flag, the sleep and calibrate control bits and the two mode pins. While a run is in progress it forces the front end into the read path for the low-reflectivity disc and sets both error-signal gains to maximum. When a run completes, it asks the control register file to go back to its defaults. It also keeps track of whether the correction currently in effect is valid.

The calibration interval is modelled by a counter. Its length is the parameter `CAL_CYCLES`, which stands in for the nominal 150 ms run. The comparators, sensors and trim converters are not part of the block; only their digital flags enter it.

There are four states:
- IDLE: the normal resting state.
- CALIBRATING: a run is in progress.
- WAIT_SUPPLY: entered from reset and after any supply droop.
- WAIT_CMD: a temperature drift has been flagged.

The transitions are:
- WAIT_SUPPLY→CALIBRATING when the supply has recovered.
- CALIBRATING→IDLE when the run completes.
- CALIBRATING→WAIT_SUPPLY when the supply droops (abort).
- IDLE→CALIBRATING on a command or on leaving sleep.
- IDLE→WAIT_CMD on a temperature drift.
- IDLE→WAIT_SUPPLY and WAIT_CMD→WAIT_SUPPLY on a droop.
- WAIT_CMD→CALIBRATING on a command or on leaving sleep.

Top module: `cal_seq`

## Requirements
- R1: Reset places the sequencer in WAIT_SUPPLY with `cal_busy`, `corr_valid`, `regs_reset_req` and `ovr_en` low. The first clock edge that sees `supply_ok`=1 and `supply_low`=0 starts a calibration.
- R2: A rising edge of `cal_bit` while `sleep_bit` is 1 starts nothing. A falling edge of `sleep_bit` in IDLE or WAIT_CMD starts a calibration.
- R3: A rising edge of `cal_bit` while `sleep_bit` is 0 starts a calibration from IDLE or WAIT_CMD. Holding `cal_bit` at 1 does not start a second run.
- R4: `cal_busy` is high for exactly `CAL_CYCLES` cycles during an uninterrupted run, then goes low.
- R5: `supply_low`=1 during a run aborts it at the next edge. A new run starts only after `supply_ok`=1 is seen in WAIT_SUPPLY. A low-then-high pulse on `supply_ok` in IDLE, without any droop, has no effect.
- R6: `temp_drift`=1 in IDLE moves the sequencer to WAIT_CMD. There `cal_busy` stays high and no run starts until a command or a sleep exit arrives.
- R7: `regs_reset_req` is a one-cycle pulse in the first cycle after a completed run. An aborted run produces no pulse.
- R8: In CALIBRATING, `force_read`=1, `ovr_en`=1 and `ovr_gain`=4'b0000 (+14 dB). In every other state, `force_read`=0, `ovr_en`=0 and `ovr_gain`=4'b0111 (0 dB).
- R9: `corr_valid` clears at the start of every run and in any cycle where `mode_a` and `mode_b` are both 1. It sets at completion only if the mode pins are not both 1 at that moment. Otherwise it stays 0 until a later run completes.
- R10: `state_oh` is one-hot: bit 0 IDLE, bit 1 CALIBRATING, bit 2 WAIT_SUPPLY, bit 3 WAIT_CMD.
- R11: When a droop arrives in the same cycle a run would complete, the abort wins. The sequencer goes to WAIT_SUPPLY, with no register reset request and `corr_valid` left at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_low | input | 1 | Supply below the droop level |
| supply_ok | input | 1 | Supply above the recovery level |
| temp_drift | input | 1 | Temperature drift since last calibration |
| sleep_bit | input | 1 | Sleep control bit |
| cal_bit | input | 1 | Calibrate control bit |
| mode_a | input | 1 | Mode pin A |
| mode_b | input | 1 | Mode pin B; both high marks correction inactive |
| cal_busy | output | 1 | Calibration busy / request status |
| force_read | output | 1 | Force low-reflectivity read path |
| ovr_en | output | 1 | Gain override enable |
| ovr_gain | output | 4 | Gain code applied to both error signals |
| corr_valid | output | 1 | Corrected output valid |
| regs_reset_req | output | 1 | Request to restore control register defaults |
| state_oh | output | 4 | One-hot state view |

## Verification
Completion of a run and a supply droop can coincide on the final counted cycle of CALIBRATING. The bench starts a run and counts to the last busy cycle. It then raises `supply_low` just before the edge that would finish the run. The expected result is WAIT_SUPPLY with no `regs_reset_req` pulse and `corr_valid` low. A second coincidence, a temperature drift arriving together with a calibrate command in IDLE, must also resolve to CALIBRATING.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    localparam int GAIN_W = 4;

    // Gain code applied while calibrating (+14 dB) and the register default (0 dB)
    localparam logic [GAIN_W-1:0] GAIN_MAX = 4'b0000;
    localparam logic [GAIN_W-1:0] GAIN_DEF = 4'b0111;

    localparam int STATE_N = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CAL  = 2'd1,
        ST_WSUP = 2'd2,
        ST_WCMD = 2'd3
    } seq_state_e;

endpackage

// File: rtl/cal_trig.sv
// Edge detection for the calibrate command and for the sleep exit
module cal_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_bit,
    input  logic sleep_bit,
    output logic cmd_pulse,
    output logic wake_pulse
);

    logic cal_q;
    logic sleep_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_q   <= 1'b0;
            sleep_q <= 1'b0;
        end else begin
            cal_q   <= cal_bit;
            sleep_q <= sleep_bit;
        end
    end

    // sleep has priority over a calibrate write (R2)
    assign cmd_pulse  = cal_bit & ~cal_q & ~sleep_bit;
    assign wake_pulse = ~sleep_bit & sleep_q;

endmodule

// File: rtl/cal_timer.sv
// Run-length counter standing in for the calibration interval
module cal_timer #(
    parameter int CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);

endmodule

// File: rtl/cal_corr.sv
// Tracks whether the correction currently in effect is valid
module cal_corr (
    input  logic clk,
    input  logic rst_n,
    input  logic inactive,
    input  logic start,
    input  logic finish,
    output logic valid
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else if (inactive || start) begin
            valid <= 1'b0;
        end else if (finish) begin
            valid <= 1'b1;
        end
    end

endmodule

// File: rtl/cal_seq.sv
module cal_seq
    import cal_seq_pkg::*;
#(
    parameter int CAL_CYCLES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_low,
    input  logic              supply_ok,
    input  logic              temp_drift,
    input  logic              sleep_bit,
    input  logic              cal_bit,
    input  logic              mode_a,
    input  logic              mode_b,
    output logic              cal_busy,
    output logic              force_read,
    output logic              ovr_en,
    output logic [GAIN_W-1:0] ovr_gain,
    output logic              corr_valid,
    output logic              regs_reset_req,
    output logic [STATE_N-1:0] state_oh
);

    seq_state_e state;
    seq_state_e nxt;

    logic cmd_pulse;
    logic wake_pulse;
    logic run_done;
    logic run_start;
    logic run_finish;
    logic regs_rst_q;

    cal_trig u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_bit    (cal_bit),
        .sleep_bit  (sleep_bit),
        .cmd_pulse  (cmd_pulse),
        .wake_pulse (wake_pulse)
    );

    cal_timer #(.CYCLES(CAL_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_CAL),
        .done  (run_done)
    );

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_WSUP: begin
                if (!supply_low && supply_ok) nxt = ST_CAL;
            end
            ST_CAL: begin
                if (supply_low)    nxt = ST_WSUP;
                else if (run_done) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (supply_low)                   nxt = ST_WSUP;
                else if (cmd_pulse || wake_pulse) nxt = ST_CAL;
                else if (temp_drift)              nxt = ST_WCMD;
            end
            ST_WCMD: begin
                if (supply_low)                   nxt = ST_WSUP;
                else if (cmd_pulse || wake_pulse) nxt = ST_CAL;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WSUP;
        else        state <= nxt;
    end

    assign run_start  = (nxt == ST_CAL) && (state != ST_CAL);
    assign run_finish = (state == ST_CAL) && run_done && !supply_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_rst_q <= 1'b0;
        else        regs_rst_q <= run_finish;
    end

    cal_corr u_corr (
        .clk      (clk),
        .rst_n    (rst_n),
        .inactive (mode_a & mode_b),
        .start    (run_start),
        .finish   (run_finish),
        .valid    (corr_valid)
    );

    // outputs
    always_comb begin
        cal_busy   = 1'b0;
        force_read = 1'b0;
        ovr_en     = 1'b0;
        ovr_gain   = GAIN_DEF;
        state_oh   = '0;
        unique case (state)
            ST_IDLE: begin
                state_oh[0] = 1'b1;
            end
            ST_CAL: begin
                state_oh[1] = 1'b1;
                cal_busy    = 1'b1;
                force_read  = 1'b1;
                ovr_en      = 1'b1;
                ovr_gain    = GAIN_MAX;
            end
            ST_WSUP: begin
                state_oh[2] = 1'b1;
            end
            ST_WCMD: begin
                state_oh[3] = 1'b1;
                cal_busy    = 1'b1;
            end
        endcase
    end

    assign regs_reset_req = regs_rst_q;

endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk
    import cal_seq_pkg::*;
#(
    parameter int CAL_CYCLES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_low,
    input logic              sleep_bit,
    input logic              mode_a,
    input logic              mode_b,
    input logic              cal_busy,
    input logic              force_read,
    input logic              ovr_en,
    input logic [GAIN_W-1:0] ovr_gain,
    input logic              corr_valid,
    input logic              regs_reset_req,
    input logic [STATE_N-1:0] state_oh
);

    int run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           run_len <= 0;
        else if (state_oh[1]) run_len <= run_len + 1;
        else                  run_len <= 0;
    end

    // R10
    onehot_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_oh) == 1);

    // R5
    droop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[1] && supply_low) |=> (state_oh[2] && !cal_busy));

    // R2
    sleep_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_oh[0] && sleep_bit) |=> !state_oh[1]);

    // R7
    regs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_reset_req |-> ($past(state_oh[1]) && state_oh[0]));

    // R4
    run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_reset_req |-> (run_len == CAL_CYCLES));

    // R8
    override_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_busy |-> (!ovr_en && !force_read && ovr_gain == GAIN_DEF));

    // R9
    inactive_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_a && mode_b) |=> !corr_valid);

    // R6
    wait_cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_oh[3] |-> (cal_busy && !ovr_en));

endmodule

bind cal_seq cal_seq_chk #(.CAL_CYCLES(CAL_CYCLES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_low     (supply_low),
    .sleep_bit      (sleep_bit),
    .mode_a         (mode_a),
    .mode_b         (mode_b),
    .cal_busy       (cal_busy),
    .force_read     (force_read),
    .ovr_en         (ovr_en),
    .ovr_gain       (ovr_gain),
    .corr_valid     (corr_valid),
    .regs_reset_req (regs_reset_req),
    .state_oh       (state_oh)
);

// File: tb/cal_seq_bench.sv
`timescale 1ns/1ps
module cal_seq_bench;

    localparam int CAL_N = 32;

    localparam logic [3:0] OH_IDLE = 4'b0001;
    localparam logic [3:0] OH_CAL  = 4'b0010;
    localparam logic [3:0] OH_WSUP = 4'b0100;
    localparam logic [3:0] OH_WCMD = 4'b1000;

    typedef struct packed {
        logic       sl;
        logic       sok;
        logic       tmp;
        logic       slp;
        logic       cal;
        logic       ma;
        logic       mb;
        logic [7:0] hold;
        logic [3:0] oh;
        logic       busy;
        logic       cv;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 27;
    // fields: sl sok tmp slp cal ma mb | hold | state busy corr_valid | requirement
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd1,  OH_CAL, 1'b1,1'b0, 4'd1}, // R1 power-up
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd32, OH_IDLE,1'b0,1'b1, 4'd4}, // R4
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'd1,  OH_CAL, 1'b1,1'b0, 4'd3}, // R3
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'd32, OH_IDLE,1'b0,1'b1, 4'd4}, // R4
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd2,  OH_IDLE,1'b0,1'b1, 4'd3}, // R3
        '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 8'd3,  OH_IDLE,1'b0,1'b1, 4'd2}, // R2 sleep wins
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'd1,  OH_CAL, 1'b1,1'b0, 4'd2}, // R2 sleep exit
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'd32, OH_IDLE,1'b0,1'b1, 4'd4}, // R4
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd1,  OH_WSUP,1'b0,1'b1, 4'd5}, // R5
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd3,  OH_WSUP,1'b0,1'b1, 4'd5}, // R5
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd1,  OH_CAL, 1'b1,1'b0, 4'd5}, // R5
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd5,  OH_WSUP,1'b0,1'b0, 4'd5}, // R5 abort
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd2,  OH_WSUP,1'b0,1'b0, 4'd5}, // R5
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd33, OH_IDLE,1'b0,1'b1, 4'd5}, // R5 restart
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd1,  OH_IDLE,1'b0,1'b1, 4'd5}, // R5 glitch
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd1,  OH_IDLE,1'b0,1'b1, 4'd5}, // R5 glitch
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 8'd1,  OH_WCMD,1'b1,1'b1, 4'd6}, // R6
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd10, OH_WCMD,1'b1,1'b1, 4'd6}, // R6
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'd1,  OH_CAL, 1'b1,1'b0, 4'd6}, // R6
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 8'd10, OH_CAL, 1'b1,1'b0, 4'd9}, // R9
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0, 8'd22, OH_IDLE,1'b0,1'b1, 4'd9}, // R9 reactivated
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 8'd1,  OH_IDLE,1'b0,1'b0, 4'd9}, // R9
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd3,  OH_IDLE,1'b0,1'b0, 4'd9}, // R9 stays
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'd33, OH_IDLE,1'b0,1'b1, 4'd9}, // R9 new run
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd1,  OH_IDLE,1'b0,1'b1, 4'd9}, // R9
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 8'd33, OH_IDLE,1'b0,1'b0, 4'd9}, // R9 inactive run
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'd2,  OH_IDLE,1'b0,1'b0, 4'd9}  // R9
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_low = 1'b0;
    logic supply_ok = 1'b1;
    logic temp_drift = 1'b0;
    logic sleep_bit = 1'b0;
    logic cal_bit = 1'b0;
    logic mode_a = 1'b0;
    logic mode_b = 1'b0;
    logic cal_busy;
    logic force_read;
    logic ovr_en;
    logic [3:0] ovr_gain;
    logic corr_valid;
    logic regs_reset_req;
    logic [3:0] state_oh;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cal_seq #(.CAL_CYCLES(CAL_N)) u_cal_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_low     (supply_low),
        .supply_ok      (supply_ok),
        .temp_drift     (temp_drift),
        .sleep_bit      (sleep_bit),
        .cal_bit        (cal_bit),
        .mode_a         (mode_a),
        .mode_b         (mode_b),
        .cal_busy       (cal_busy),
        .force_read     (force_read),
        .ovr_en         (ovr_en),
        .ovr_gain       (ovr_gain),
        .corr_valid     (corr_valid),
        .regs_reset_req (regs_reset_req),
        .state_oh       (state_oh)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_reset_state(input string req);
        check(req, "state_oh", {4'b0, state_oh}, {4'b0, OH_WSUP});
        check(req, "busy/cv/regs/ovr", {4'b0, cal_busy, corr_valid, regs_reset_req, ovr_en}, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int busy_cnt;
        repeat (3) @(negedge clk);
        check_reset_state("R1");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            supply_low = VECS[i].sl;
            supply_ok  = VECS[i].sok;
            temp_drift = VECS[i].tmp;
            sleep_bit  = VECS[i].slp;
            cal_bit    = VECS[i].cal;
            mode_a     = VECS[i].ma;
            mode_b     = VECS[i].mb;
            repeat (int'(VECS[i].hold)) @(negedge clk);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), "state/busy/cv",
                  {2'b0, state_oh, cal_busy, corr_valid},
                  {2'b0, VECS[i].oh, VECS[i].busy, VECS[i].cv});
            check("R10", "onehot", 8'($countones(state_oh)), 8'd1);
        end

        // R8 idle override values
        check("R8", "idle override", {2'b0, force_read, ovr_en, ovr_gain}, 8'h07);

        // R8 / R4 / R7 full run
        cal_bit = 1'b0;
        @(negedge clk);
        cal_bit = 1'b1;
        @(negedge clk);
        check("R8", "cal override", {2'b0, force_read, ovr_en, ovr_gain}, 8'h30);
        busy_cnt = 1;
        while (cal_busy && busy_cnt < 100) begin
            @(negedge clk);
            if (cal_busy) busy_cnt++;
        end
        check("R4", "busy length", 8'(busy_cnt), 8'(CAL_N));
        check("R7", "regs reset pulse", {7'b0, regs_reset_req}, 8'd1);
        @(negedge clk);
        check("R7", "regs reset width", {7'b0, regs_reset_req}, 8'd0);

        // R11 droop on the completing cycle
        cal_bit = 1'b0;
        @(negedge clk);
        cal_bit = 1'b1;
        repeat (CAL_N) @(negedge clk);
        check("R11", "last busy cycle", {7'b0, cal_busy}, 8'd1);
        supply_low = 1'b1;
        supply_ok  = 1'b0;
        @(negedge clk);
        check("R11", "abort wins", {2'b0, state_oh, regs_reset_req, corr_valid},
              {2'b0, OH_WSUP, 1'b0, 1'b0});
        @(negedge clk);
        check("R11", "no late pulse", {7'b0, regs_reset_req}, 8'd0);

        // recover, then drift together with a command
        supply_low = 1'b0;
        supply_ok  = 1'b1;
        cal_bit    = 1'b0;
        repeat (CAL_N + 4) @(negedge clk);
        check("R5", "recovered", {4'b0, state_oh}, {4'b0, OH_IDLE});
        cal_bit    = 1'b1;
        temp_drift = 1'b1;
        @(negedge clk);
        check("R3", "cmd beats drift", {4'b0, state_oh}, {4'b0, OH_CAL});
        temp_drift = 1'b0;

        // R1 reset in the middle of a run
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("R1");

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule